// File: doc/BRIEF.md
# Interleaved Latch Delay Line

This block delays a serial bit stream by a fixed 791 clock cycles. Its storage is level-sensitive latches rather than edge-triggered flops. The storage is split into eight lanes. Each incoming bit goes to the next lane in round-robin order, and the output selects lanes in the same rotation. A lane therefore takes one new bit every eight clocks, while the line as a whole accepts and delivers one bit per clock.

Inside a lane, latches form groups of four. Four enable pulses, spaced two clocks apart and never overlapping, move the data one latch per pulse. A group holds only three bits, because one empty slot must travel backwards so that a latch never copies from a neighbour that is transparent at the same time. A small sequencer produces eight staggered one-hot pulses, one per clock. Each lane draws its four enables from four of those pulses, so each pulse touches one eighth of the latches. Reset drives every pulse high and clears every latch, which flushes the line.

Top module: `interleaved_delay`

## Requirements
- R1: A bit on `dIn` sampled at rising edge t appears on `dOut` just after rising edge t+791 (with the default of 33 groups per lane), and not one cycle before or after.
- R2: While `rst` is high, and for the first 791 cycles after it is released, `dOut` is 0, whatever the line held before reset.
- R3: While `rst` is high, all eight bits of `phasePulse` are 1.
- R4: Out of reset, exactly one bit of `phasePulse` is 1. In the first cycle after release it is bit 0, and after each rising edge it moves from bit k to bit (k+1) mod 8. Lane L is enabled by pulses L, L+2, L+4 and L+6 (mod 8).
- R5: Any bit pattern, including alternating bits, long runs and pseudo-random data, is reproduced bit for bit at full rate, with consecutive bits held in different lanes.
- R6: `dOut` changes only just after a rising clock edge and holds steady through the rest of the cycle.
- R7: Within a lane, no two of its four latch enables are active together outside reset, and a lane's input holding register is never loaded while that lane's first latch is transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one bit enters and one bit leaves per rising edge |
| rst | input | 1 | Synchronous reset, active high; also forces all pulses active |
| dIn | input | 1 | Serial data input |
| dOut | output | 1 | Registered serial data output, delayed by 791 cycles |
| phasePulse | output | 8 | One-hot staggered enable pulses, all high during reset |

## Verification
On every cycle, the embedded properties check three things: that the pulse vector stays one-hot and rotates by one position, that each lane's four enables stay non-overlapping, and that no lane's holding register reloads while its first latch is open. They also check that reset forces every enable high and clears the output. The exact 791-cycle latency, the faithful reproduction of several data patterns, and the discarding of old contents by a mid-stream reset depend on the whole chain of latches. Only the bench's directed streams can show these, by comparing `dOut` with a history of the driven bits.

// File: rtl/dld_pkg.sv
package dld_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int PHASES = 4;
  localparam int PH_GAP = LANES / PHASES;

  typedef struct packed {
    logic [LANES-1:0]             holdLoad;
    logic [LANES-1:0][PHASES-1:0] phaseEn;
    logic [LANE_W-1:0]            rdLane;
  } dldStrobe_t;
endpackage

// File: rtl/dld_ctrl.sv
module dld_ctrl
  import dld_pkg::*;
#(
  parameter int GROUPS = 33
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LANES-1:0] slotPulse,
  output dldStrobe_t       strobe
);
  localparam int DELAY    = LANES * (PHASES - 1) * GROUPS - 1;
  localparam int READ_OFS = (LANES - ((DELAY - 1) % LANES)) % LANES;

  logic [LANE_W-1:0] slotCnt;
  logic [LANES-1:0]  slotOneHot;

  always_ff @(posedge clk) begin
    if (rst) slotCnt <= '0;
    else     slotCnt <= slotCnt + 1'b1;
  end

  assign slotOneHot      = LANES'(1) << slotCnt;
  assign slotPulse       = rst ? '1 : slotOneHot;
  assign strobe.holdLoad = {slotOneHot[LANES-2:0], slotOneHot[LANES-1]};
  assign strobe.rdLane   = slotCnt + LANE_W'(READ_OFS);

  for (genvar l = 0; l < LANES; l++) begin : gLaneEn
    for (genvar q = 0; q < PHASES; q++) begin : gPhase
      assign strobe.phaseEn[l][q] = slotPulse[(l + PH_GAP * q) % LANES];
    end
  end

  assert_pulse_onehot_R4 : assert property (@(posedge clk) disable iff (rst)
    $countones(slotPulse) == 1);

  assert_pulse_step_R4 : assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> slotPulse == {$past(slotPulse[LANES-2:0]), $past(slotPulse[LANES-1])});
endmodule

// File: rtl/dld_lane.sv
module dld_lane
  import dld_pkg::*;
#(
  parameter int GROUPS = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              laneIn,
  input  logic [PHASES-1:0] phEn,
  output logic              laneOut
);
  localparam int CELLS = PHASES * GROUPS;

  for (genvar j = 0; j < CELLS; j++) begin : gCell
    localparam int PH = (PHASES - (j % PHASES)) % PHASES;
    logic src;
    logic q;
    if (j == 0) begin : gHead
      assign src = laneIn;
    end else begin : gBody
      assign src = gCell[j-1].q;
    end
    // Transparent while its phase enable is high; the element behind it
    // belongs to a different phase, so it is opaque at that time.
    always_latch begin
      if (rst)           q = 1'b0;
      else if (phEn[PH]) q = src;
    end
  end

  assign laneOut = gCell[CELLS-1].q;

  assert_phase_disjoint_R7 : assert property (@(posedge clk) disable iff (rst)
    $countones(phEn) <= 1);
endmodule

// File: rtl/dld_datapath.sv
module dld_datapath
  import dld_pkg::*;
#(
  parameter int GROUPS = 33
) (
  input  logic       clk,
  input  logic       rst,
  input  dldStrobe_t strobe,
  input  logic       dIn,
  output logic       dOut
);
  logic [LANES-1:0] holdBit;
  logic [LANES-1:0] laneTail;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst)                     holdBit[l] <= 1'b0;
      else if (strobe.holdLoad[l]) holdBit[l] <= dIn;
    end

    dld_lane #(.GROUPS(GROUPS)) i_lane (
      .clk    (clk),
      .rst    (rst),
      .laneIn (holdBit[l]),
      .phEn   (strobe.phaseEn[l]),
      .laneOut(laneTail[l])
    );

    assert_hold_quiet_R7 : assert property (@(posedge clk) disable iff (rst)
      !(strobe.holdLoad[l] && strobe.phaseEn[l][0]));
  end

  always_ff @(posedge clk) begin
    if (rst) dOut <= 1'b0;
    else     dOut <= laneTail[strobe.rdLane];
  end

  assert_flush_open_R3 : assert property (@(posedge clk)
    rst |-> (&strobe.phaseEn));

  assert_out_clear_R2 : assert property (@(posedge clk)
    rst |=> !dOut);
endmodule

// File: rtl/interleaved_delay.sv
module interleaved_delay
  import dld_pkg::*;
#(
  parameter int GROUPS = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dIn,
  output logic             dOut,
  output logic [LANES-1:0] phasePulse
);
  dldStrobe_t strobe;

  dld_ctrl #(.GROUPS(GROUPS)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .slotPulse(phasePulse),
    .strobe   (strobe)
  );

  dld_datapath #(.GROUPS(GROUPS)) i_datapath (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .dIn   (dIn),
    .dOut  (dOut)
  );
endmodule

// File: tb/test_interleaved_delay.sv
module test_interleaved_delay;
  localparam int CLK_PERIOD = 10;
  localparam int GROUPS     = 33;
  localparam int DLY        = 24 * GROUPS - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dIn = 1'b0;
  logic       dOut;
  logic [7:0] phasePulse;
  logic       hist [0:4095];
  logic [7:0] lfsr;
  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interleaved_delay #(.GROUPS(GROUPS)) i_interleaved_delay (
    .clk       (clk),
    .rst       (rst),
    .dIn       (dIn),
    .dOut      (dOut),
    .phasePulse(phasePulse)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R2, R3 while held; R4 first pulse after release
  task automatic applyReset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    dIn = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R2", "dOut in reset", {7'b0, dOut}, 8'h00);
      chk("R3", "pulses in reset", phasePulse, 8'hFF);
    end
    rst = 1'b0;
    #1;
    chk("R4", "first pulse after release", phasePulse, 8'h01);
  endtask

  // mode 0 zeros, 1 alternating, 2 pseudo-random, 3 single one, 4 ones, 5 runs of 7
  task automatic runStream(int mode, int cycles, string tag);
    logic b;
    logic [7:0] seen;
    lfsr = 8'hA5;
    for (int n = 0; n < cycles; n++) begin
      case (mode)
        1:       b = n[0];
        2:       begin b = lfsr[0]; lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; end
        3:       b = (n == 0);
        4:       b = 1'b1;
        5:       b = ((n / 7) % 2) == 1;
        default: b = 1'b0;
      endcase
      hist[n] = b;
      dIn = b;
      @(negedge clk);
      if (n >= DLY) chk(tag, "delayed bit", {7'b0, dOut}, {7'b0, hist[n-DLY]});
      else          chk("R2", "empty line after reset", {7'b0, dOut}, 8'h00);
      chk("R4", "pulse rotation", phasePulse, 8'(1) << ((n + 1) % 8));
      seen = {7'b0, dOut};
      #(CLK_PERIOD/2 - 2);
      chk("R6", "dOut steady mid-cycle", {7'b0, dOut}, seen);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    checkCount++;
    $display("FAIL R5 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    // R1: isolated one lands exactly DLY cycles later (R7 pulses checked per cycle)
    applyReset(3);
    runStream(3, DLY + 12, "R1");
    // R5: several patterns at full rate
    applyReset(2);
    runStream(1, DLY + 300, "R5");
    applyReset(2);
    runStream(2, DLY + 600, "R5");
    applyReset(2);
    runStream(5, DLY + 300, "R5");
    // R2: reset mid-stream discards contents, then ones fill in
    applyReset(1);
    runStream(2, 1000, "R5");
    applyReset(4);
    runStream(4, DLY + 200, "R2");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule